// File: doc/BRIEF.md
# Serial Port Clock Source Selector

This block chooses where the bit clock of a serial port comes from and how the port's clock pad behaves. The port runs either asynchronously (start/stop framing with 16x oversampling) or in clocked synchronous mode. A 2-bit source field and the mode bit together set three things: the clock source (internal or from the pad), the pad direction, and the oversampling ratio. The block turns these into single-cycle enables for the transmit and receive engines.

With an internal source the block passes on a bit-rate tick and a 16x tick from a baud generator outside the block. When the pad is to carry a clock, the block builds a square wave whose period is one bit. With an external source the pad goes through a synchronizer and its edges are found in the system clock domain. In asynchronous mode the pad clock runs at 16 times the bit rate and is divided down. In synchronous mode its falling and rising edges become the shift and sample enables. Any change to the configuration restarts the divider.

Top module: `serial_clk_select`

## Requirements
- R1: While reset is held and right after it, with mode 0, field 00 and both ticks low, padOe, padOut, bitEn and sampleEn are all 0.
- R2: Asynchronous mode, field 00: padOe and padOut stay 0, bitEn equals bitTick and sampleEn equals ovsTick in the same cycle, and activity on padIn has no effect on any output.
- R3: Asynchronous mode, field 01: padOe is 1. padOut is 0 while fewer than 8 ovsTick pulses have come since the last bitTick, and 1 from the 8th to the 15th, so its period is one bit. bitEn and sampleEn follow bitTick and ovsTick.
- R4: Asynchronous mode, field 10 or 11: padOe and padOut are 0, bitTick and ovsTick are ignored, and sampleEn pulses for one cycle for each rising edge of padIn.
- R5: Asynchronous mode, field 10 or 11: bitEn pulses together with sampleEn on every 16th rising edge of padIn, counted from the last configuration change.
- R6: Synchronous mode, field 00 or 01: padOe is 1 and padOut has the R3 waveform. bitEn equals bitTick. sampleEn pulses on the ovsTick that moves the count from 7 to 8, which is the pad's mid-bit rising edge.
- R7: Synchronous mode, field 10 or 11: padOe and padOut are 0, bitEn pulses on each falling edge of padIn and sampleEn on each rising edge, never both in one cycle.
- R8: Any change of the mode bit or the field clears the divide counter, so the next bit enable in asynchronous external mode comes on the 16th rising edge after the change.
- R9: A level change on padIn shows up as a one-cycle enable in the cycle that follows the second clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| syncMode | input | 1 | 0 asynchronous, 1 clocked synchronous |
| clkSel | input | 2 | Clock source / pad role field |
| bitTick | input | 1 | Internal bit-rate pulse |
| ovsTick | input | 1 | Internal 16x oversample pulse |
| padIn | input | 1 | Clock pad input value |
| padOut | output | 1 | Clock pad output value |
| padOe | output | 1 | Clock pad output enable |
| bitEn | output | 1 | Bit / transmit shift enable |
| sampleEn | output | 1 | Oversample / receive sample enable |

## Verification
Every mode and field pair is run with a free-running tick pattern (a bit tick every 64 cycles and an oversample tick every 4). At the same time padIn toggles with half-periods of 2, 3, 5 and 7 cycles. The internal modes show whether the pad input is truly ignored and whether the output waveform lines up with the bit tick. The external modes show edge polarity, the two-edge synchronizer delay and the divide-by-16 phase. The different pad periods tell an edge detector apart from a level detector. A switch from field 10 to 11 after ten edges shows whether the divider restarts.

// File: rtl/serial_clk_pkg.sv
package serial_clk_pkg;

  typedef enum logic [2:0] {
    SRC_QUIET    = 3'd0,
    SRC_CLKOUT   = 3'd1,
    SRC_EXT16    = 3'd2,
    SRC_SYNC_INT = 3'd3,
    SRC_SYNC_EXT = 3'd4
  } srcMode_e;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } cntCmd_t;

endpackage

// File: rtl/serial_clk_dp.sv
module serial_clk_dp
  import serial_clk_pkg::*;
#(
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    padIn,
  input  cntCmd_t cmd,
  output logic    padRise,
  output logic    padFall,
  output logic    cntTerm,
  output logic    cntMid,
  output logic    waveLvl
);

  localparam logic [DIV_W-1:0] TERM_VAL = '1;
  localparam logic [DIV_W-1:0] MID_VAL  = {1'b0, {(DIV_W-1){1'b1}}};

  logic [SYNC_STAGES:0] shReg;
  logic [DIV_W-1:0]     cnt;
  logic                 syncLvl;
  logic                 prevLvl;

  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) shReg[0] <= 1'b0;
          else        shReg[0] <= padIn;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) shReg[g] <= 1'b0;
          else        shReg[g] <= shReg[g-1];
        end
      end
    end
  endgenerate

  assign syncLvl = shReg[SYNC_STAGES-1];
  assign prevLvl = shReg[SYNC_STAGES];
  assign padRise = syncLvl & ~prevLvl;
  assign padFall = ~syncLvl & prevLvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cmd.cntClr) cnt <= '0;
    else if (cmd.cntInc) cnt <= cnt + 1'b1;
  end

  assign cntTerm = (cnt == TERM_VAL);
  assign cntMid  = (cnt == MID_VAL);
  assign waveLvl = cnt[DIV_W-1];

  assert_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.cntClr |=> (cnt == '0));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.cntInc && !cmd.cntClr && cnt == TERM_VAL) |=> (cnt == '0));

  assert_rise_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    padRise |=> !padRise);

  assert_fall_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    padFall |=> !padFall);

endmodule

// File: rtl/serial_clk_ctrl.sv
module serial_clk_ctrl
  import serial_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       syncMode,
  input  logic [1:0] clkSel,
  input  logic       bitTick,
  input  logic       ovsTick,
  input  logic       padRise,
  input  logic       padFall,
  input  logic       cntTerm,
  input  logic       cntMid,
  input  logic       waveLvl,
  output cntCmd_t    cmd,
  output logic       padOut,
  output logic       padOe,
  output logic       bitEn,
  output logic       sampleEn
);

  logic [2:0] cfgNow;
  logic [2:0] cfgPrev;
  logic       cfgChanged;
  logic       internalSrc;
  srcMode_e   mode;

  assign cfgNow = {syncMode, clkSel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfgPrev <= 3'b000;
    else        cfgPrev <= cfgNow;
  end

  assign cfgChanged = (cfgNow != cfgPrev);

  always_comb begin
    if (syncMode) mode = clkSel[1] ? SRC_SYNC_EXT : SRC_SYNC_INT;
    else begin
      unique case (clkSel)
        2'b00:   mode = SRC_QUIET;
        2'b01:   mode = SRC_CLKOUT;
        default: mode = SRC_EXT16;
      endcase
    end
  end

  assign internalSrc = ~clkSel[1];

  always_comb begin
    cmd.cntClr = cfgChanged | (internalSrc & bitTick);
    cmd.cntInc = internalSrc ? ovsTick : ((mode == SRC_EXT16) & padRise);
  end

  always_comb begin
    padOut   = 1'b0;
    padOe    = 1'b0;
    bitEn    = 1'b0;
    sampleEn = 1'b0;
    unique case (mode)
      SRC_QUIET: begin
        bitEn    = bitTick;
        sampleEn = ovsTick;
      end
      SRC_CLKOUT: begin
        padOe    = 1'b1;
        padOut   = waveLvl;
        bitEn    = bitTick;
        sampleEn = ovsTick;
      end
      SRC_EXT16: begin
        sampleEn = padRise;
        bitEn    = padRise & cntTerm & ~cfgChanged;
      end
      SRC_SYNC_INT: begin
        padOe    = 1'b1;
        padOut   = waveLvl;
        bitEn    = bitTick;
        sampleEn = ovsTick & cntMid & ~bitTick;
      end
      SRC_SYNC_EXT: begin
        bitEn    = padFall;
        sampleEn = padRise;
      end
      default: ;
    endcase
  end

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_QUIET) |-> (!padOe && !padOut));

  assert_ext_nodrive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clkSel[1] |-> !padOe);

  assert_bit_with_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_EXT16 && bitEn) |-> sampleEn);

  assert_sync_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_SYNC_EXT) |-> !(bitEn && sampleEn));

endmodule

// File: rtl/serial_clk_select.sv
module serial_clk_select
  import serial_clk_pkg::*;
#(
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       syncMode,
  input  logic [1:0] clkSel,
  input  logic       bitTick,
  input  logic       ovsTick,
  input  logic       padIn,
  output logic       padOut,
  output logic       padOe,
  output logic       bitEn,
  output logic       sampleEn
);

  cntCmd_t cmd;
  logic    padRise;
  logic    padFall;
  logic    cntTerm;
  logic    cntMid;
  logic    waveLvl;

  serial_clk_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .syncMode (syncMode),
    .clkSel   (clkSel),
    .bitTick  (bitTick),
    .ovsTick  (ovsTick),
    .padRise  (padRise),
    .padFall  (padFall),
    .cntTerm  (cntTerm),
    .cntMid   (cntMid),
    .waveLvl  (waveLvl),
    .cmd      (cmd),
    .padOut   (padOut),
    .padOe    (padOe),
    .bitEn    (bitEn),
    .sampleEn (sampleEn)
  );

  serial_clk_dp #(
    .DIV_W       (DIV_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .padIn   (padIn),
    .cmd     (cmd),
    .padRise (padRise),
    .padFall (padFall),
    .cntTerm (cntTerm),
    .cntMid  (cntMid),
    .waveLvl (waveLvl)
  );

endmodule

// File: tb/serial_clk_select_tb.sv
module serial_clk_select_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       syncMode = 1'b0;
  logic [1:0] clkSel = 2'b00;
  logic       bitTick = 1'b0;
  logic       ovsTick = 1'b0;
  logic       padIn = 1'b0;
  logic       padOut, padOe, bitEn, sampleEn;

  int total = 0;
  int bad = 0;
  int gcyc = 0;
  int riseCnt = 0;
  bit waveValid = 1'b0;
  bit hist [0:3] = '{0, 0, 0, 0};
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serial_clk_select dut_i (
    .clk(clk), .rst_n(rst_n), .syncMode(syncMode), .clkSel(clkSel),
    .bitTick(bitTick), .ovsTick(ovsTick), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .bitEn(bitEn), .sampleEn(sampleEn)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic runCycles(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      int p;
      int pp;
      bit rise;
      bit fall;
      bit internal;
      bit expOut;
      bit expOe;
      bit expBit;
      bit expSmp;
      bit chkSmp;
      @(negedge clk);
      gcyc++;
      p  = gcyc % 64;
      pp = (gcyc - 1) % 64;
      bitTick = (p == 0);
      ovsTick = (p % 4 == 0);
      for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = (half == 0) ? 1'b0 : 1'(((gcyc / half) % 2));
      padIn = hist[0];
      #1;
      rise = hist[2] && !hist[3];
      fall = !hist[2] && hist[3];
      internal = !clkSel[1];
      expOe = 1'b0; expOut = 1'b0; expBit = 1'b0; expSmp = 1'b0; chkSmp = 1'b1;
      if (!syncMode && clkSel == 2'b00) begin
        expBit = (p == 0); expSmp = (p % 4 == 0);
      end else if (!syncMode && clkSel == 2'b01) begin
        expOe = 1'b1; expOut = ((pp / 4) >= 8);
        expBit = (p == 0); expSmp = (p % 4 == 0);
      end else if (!syncMode) begin
        expSmp = rise;
        expBit = rise && (((riseCnt + 1) % 16) == 0);
        if (rise) riseCnt++;
      end else if (!clkSel[1]) begin
        expOe = 1'b1; expOut = ((pp / 4) >= 8);
        expBit = (p == 0); expSmp = (p == 32); chkSmp = waveValid;
      end else begin
        expBit = fall; expSmp = rise;
      end
      if (!syncMode && clkSel == 2'b00) begin
        chk(padOe == expOe && padOut == expOut, "R2 pad idle", {padOe, padOut}, {expOe, expOut});
        chk(bitEn == expBit && sampleEn == expSmp, "R2 tick pass", {bitEn, sampleEn}, {expBit, expSmp});
      end else if (!syncMode && clkSel == 2'b01) begin
        chk(padOe == 1'b1, "R3 pad oe", padOe, 1);
        if (waveValid) chk(padOut == expOut, "R3 pad wave", padOut, expOut);
        chk(bitEn == expBit && sampleEn == expSmp, "R3 tick pass", {bitEn, sampleEn}, {expBit, expSmp});
      end else if (!syncMode) begin
        chk(padOe == 1'b0 && padOut == 1'b0, "R4 pad input", {padOe, padOut}, 0);
        chk(sampleEn == expSmp, "R4 R9 sample on rise", sampleEn, expSmp);
        chk(bitEn == expBit, "R5 R8 bit every 16", bitEn, expBit);
      end else if (!clkSel[1]) begin
        chk(padOe == 1'b1, "R6 pad oe", padOe, 1);
        if (waveValid) chk(padOut == expOut, "R6 pad wave", padOut, expOut);
        chk(bitEn == expBit, "R6 shift on tick", bitEn, expBit);
        if (chkSmp) chk(sampleEn == expSmp, "R6 mid-bit sample", sampleEn, expSmp);
      end else begin
        chk(padOe == 1'b0 && padOut == 1'b0, "R7 pad input", {padOe, padOut}, 0);
        chk(bitEn == expBit, "R7 R9 shift on fall", bitEn, expBit);
        chk(sampleEn == expSmp, "R7 R9 sample on rise", sampleEn, expSmp);
      end
      if (internal && p == 0) waveValid = 1'b1;
    end
  endtask

  task automatic setCfg(input bit m, input logic [1:0] sel);
    runCycles(4, 0);
    syncMode  = m;
    clkSel    = sel;
    riseCnt   = 0;
    waveValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(padOe == 0 && padOut == 0 && bitEn == 0 && sampleEn == 0,
        "R1 in reset", {padOe, padOut, bitEn, sampleEn}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(padOe == 0 && padOut == 0 && bitEn == 0 && sampleEn == 0,
        "R1 after reset", {padOe, padOut, bitEn, sampleEn}, 0);

    runCycles(200, 3);
    setCfg(0, 2'b01); runCycles(300, 2);
    setCfg(0, 2'b10); runCycles(300, 3);
    setCfg(0, 2'b11); runCycles(250, 7);
    setCfg(0, 2'b10); runCycles(60, 3);
    syncMode = 0; clkSel = 2'b11; riseCnt = 0;
    runCycles(200, 3);
    setCfg(1, 2'b00); runCycles(300, 5);
    setCfg(1, 2'b01); runCycles(200, 2);
    setCfg(1, 2'b10); runCycles(200, 3);
    setCfg(1, 2'b11); runCycles(150, 5);
    setCfg(0, 2'b00); runCycles(100, 2);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule